// File: doc/BRIEF.md
# Serial Burst Data-Phase Engine

This block carries the data phase of a debug burst between a bit-serial scan path and a simple request/acknowledge bus master port. After a burst has been decoded elsewhere, one `start` pulse hands over the direction, the word size, the first address and the word count. From then on, every cycle with `shift_en` high is one scan bit. `tdi` carries the bit coming in. `tdo` carries the bit going out, and it is valid during the cycle in which it is shifted.

On a read, the engine fetches each word from the bus into a holding register one word ahead of the scan. For each word it sends a framing bit of 1 when the word is ready, and 0 while it is not. The word follows, least significant bit first. A 32-bit checksum closes the burst.

On a write, the engine waits for a 1 start bit and then assembles each word from `tdi`. It issues one bus write per word. After each word it answers with one status bit. The host's 32-bit checksum follows the last word, and the engine answers it with a single match bit. A bus error raises a sticky flag and records the failing address. The accesses that follow still finish their handshakes.

The state machine has nine states:
- `ST_IDLE` moves to `ST_RD_STATUS` or `ST_WR_WAIT` when `start` arrives with a non-zero count.
- `ST_RD_STATUS` moves to `ST_RD_DATA` when a shift sees a fetched word.
- `ST_RD_DATA` moves on after the last bit of a word: back to `ST_RD_STATUS` if words remain, otherwise to `ST_RD_CRC`.
- `ST_RD_CRC` moves to `ST_IDLE` after 32 shifts.
- `ST_WR_WAIT` moves to `ST_WR_DATA` on a shifted 1.
- `ST_WR_DATA` moves to `ST_WR_STATUS` after the last bit of a word.
- `ST_WR_STATUS` moves, on one shift, back to `ST_WR_DATA` if words remain, otherwise to `ST_WR_CRC`.
- `ST_WR_CRC` moves to `ST_WR_MATCH` after 32 shifts.
- `ST_WR_MATCH` moves to `ST_IDLE` after one shift.

Top module: `burst_xfer_engine`

## Requirements
- R1: The checksum is updated one bit at a time. For each bit, fb = bit XOR crc[0]; then crc = (crc >> 1) XOR (fb ? 0xEDB88320 : 0). It starts at 0xFFFFFFFF on every accepted `start`, covers only the data words, and takes each word least significant bit first.
- R2: On a read, `tdo` is 0 on every shift before the next word has been acknowledged by the bus. The first shift after that gives 1, and the following shifts give the word least significant bit first.
- R3: After the last read word, the next 32 shifts give the checksum least significant bit first. The engine then returns to idle, with `busy` at 0.
- R4: On a write, shifted bits are ignored until the first 1. After that 1, each group of word-size shifts forms one word, least significant bit first, and that word is written to the bus at its address.
- R5: After each written word, one shift gives a status bit. The bit is 1 when no earlier bus write was still pending at the word's last bit. When the bit is 0, that word is not written to the bus.
- R6: After the last written word, 32 shifts carry the host checksum. The next shift gives 1 exactly when it equals the engine's own checksum.
- R7: `start_size` 0 selects 8-bit words, 1 selects 16-bit words, and 2 or 3 selects 32-bit words. The address advances by 1, 2 or 4 per word. Read data is taken from the low bits of `bus_rdata`, and written data is zero-extended.
- R8: `bus_req` stays high, with address and direction stable, until `bus_ack`. A read fetches at most one word ahead of the scan.
- R9: A `bus_ack` with `bus_err` sets `err_flag`, which stays set until reset. `err_addr` keeps the address of the first failing access only.
- R10: A `start` with a zero word count is ignored. A `start` while `busy` is high is ignored.
- R11: After reset, `busy`, `tdo`, `bus_req` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a data phase with the parameters below |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| start_size | input | 2 | Word size code (0: 8, 1: 16, 2/3: 32 bits) |
| start_addr | input | ADDR_W | First word address |
| word_count | input | CNT_W | Number of words in the burst |
| shift_en | input | 1 | One scan bit moves this cycle |
| tdi | input | 1 | Scan input bit |
| tdo | output | 1 | Scan output bit |
| busy | output | 1 | Data phase in progress |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | ADDR_W | Bus access address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ack | input | 1 | Bus access complete |
| bus_err | input | 1 | Access failed, valid with bus_ack |
| err_flag | output | 1 | Sticky bus error flag |
| err_addr | output | ADDR_W | Address of the first failing access |

## Verification
The bench goes after the framing: it polls the read status bit under slow and instant acknowledges. A design that shifted before the fetch landed would return stale words, and one that misplaced the first checksum bit would fail the checksum compare. Write bursts are preceded by runs of zeros, so a design that counted from the first shift would mis-assemble every word. A slow bus forces a dropped write, which shows up either as a missing 0 status or as an extra bus write. Corrupted host checksums must flip the match bit. A burst that hits several bus errors checks that the first address is kept and not overwritten by later ones.

// File: rtl/burst_xfer_pkg.sv
package burst_xfer_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_STATUS,
        ST_RD_DATA,
        ST_RD_CRC,
        ST_WR_WAIT,
        ST_WR_DATA,
        ST_WR_STATUS,
        ST_WR_CRC,
        ST_WR_MATCH
    } xfer_state_e;

    localparam logic [31:0] CRC32_REFLECTED = 32'hEDB88320;

endpackage

// File: rtl/burst_crc_serial.sv
module burst_crc_serial #(
    parameter int          CRC_W = 32,
    parameter logic [31:0] POLY  = 32'hEDB88320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_nxt
);
    logic fb;

    always_comb begin
        fb      = din ^ crc_q[0];
        crc_nxt = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc_q <= '1;
        else if (init)  crc_q <= '1;
        else if (step)  crc_q <= crc_nxt;
    end
endmodule

// File: rtl/burst_bus_port.sv
module burst_bus_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_we,
    input  logic [ADDR_W-1:0] launch_addr,
    input  logic [DATA_W-1:0] launch_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              done,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    assign done = bus_req & bus_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (launch && !bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= launch_we;
            bus_addr  <= launch_addr;
            bus_wdata <= launch_wdata;
        end else if (done) begin
            bus_req   <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_addr <= '0;
        end else if (done && bus_err && !err_flag) begin
            err_flag <= 1'b1;
            err_addr <= bus_addr;
        end
    end
endmodule

// File: rtl/burst_xfer_engine.sv
module burst_xfer_engine
    import burst_xfer_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int CRC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [1:0]        start_size,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              shift_en,
    input  logic              tdi,
    output logic              tdo,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              err_flag,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int SH_W  = (DATA_W > CRC_W) ? DATA_W : CRC_W;
    localparam int BIT_W = $clog2(SH_W);

    xfer_state_e state, state_nxt;

    logic [1:0]        size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  fetch_left, word_left;
    logic [BIT_W-1:0]  bitcnt;
    logic [SH_W-1:0]   shreg, wword;
    logic [DATA_W-1:0] hold, rmask;
    logic              hold_vld, wr_ok, match_q;
    logic [BIT_W:0]    wbits;
    logic [ADDR_W-1:0] wbytes;
    logic              start_ok, last_bit, crc_last, last_word;
    logic              rd_launch, wr_launch, launch, done;
    logic              crc_step, crc_din;
    logic [CRC_W-1:0]  crc_q, crc_nxt;

    always_comb begin
        unique case (size_q)
            2'd0:    wbits = (BIT_W+1)'(8);
            2'd1:    wbits = (BIT_W+1)'(16);
            default: wbits = (BIT_W+1)'(32);
        endcase
        wbytes    = ADDR_W'(wbits >> 3);
        rmask     = ~({DATA_W{1'b1}} << wbits);
        start_ok  = (state == ST_IDLE) && start && (word_count != '0);
        last_bit  = ({1'b0, bitcnt} == wbits - 1'b1);
        crc_last  = (bitcnt == BIT_W'(CRC_W-1));
        last_word = (word_left == CNT_W'(1));
        wword     = shreg | (SH_W'(tdi) << bitcnt);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:      if (start_ok) state_nxt = start_write ? ST_WR_WAIT : ST_RD_STATUS;
            ST_RD_STATUS: if (shift_en && hold_vld) state_nxt = ST_RD_DATA;
            ST_RD_DATA:   if (shift_en && last_bit) state_nxt = last_word ? ST_RD_CRC : ST_RD_STATUS;
            ST_RD_CRC:    if (shift_en && crc_last) state_nxt = ST_IDLE;
            ST_WR_WAIT:   if (shift_en && tdi) state_nxt = ST_WR_DATA;
            ST_WR_DATA:   if (shift_en && last_bit) state_nxt = ST_WR_STATUS;
            ST_WR_STATUS: if (shift_en) state_nxt = last_word ? ST_WR_CRC : ST_WR_DATA;
            ST_WR_CRC:    if (shift_en && crc_last) state_nxt = ST_WR_MATCH;
            ST_WR_MATCH:  if (shift_en) state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        tdo       = 1'b0;
        rd_launch = 1'b0;
        wr_launch = 1'b0;
        crc_step  = 1'b0;
        crc_din   = tdi;
        unique case (state)
            ST_RD_STATUS, ST_RD_DATA, ST_RD_CRC: begin
                rd_launch = (fetch_left != '0) && !hold_vld && !bus_req;
                if (state == ST_RD_STATUS) tdo = hold_vld;
                else                       tdo = shreg[0];
                if (state == ST_RD_DATA) begin
                    crc_step = shift_en;
                    crc_din  = shreg[0];
                end
            end
            ST_WR_DATA: begin
                crc_step  = shift_en;
                wr_launch = shift_en && last_bit && !bus_req;
            end
            ST_WR_STATUS: tdo = wr_ok;
            ST_WR_MATCH:  tdo = match_q;
            default: ;
        endcase
        launch = rd_launch | wr_launch;
        busy   = (state != ST_IDLE);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q     <= '0;
            addr_q     <= '0;
            fetch_left <= '0;
            word_left  <= '0;
            bitcnt     <= '0;
            shreg      <= '0;
            hold       <= '0;
            hold_vld   <= 1'b0;
            wr_ok      <= 1'b0;
            match_q    <= 1'b0;
        end else if (start_ok) begin
            size_q     <= start_size;
            addr_q     <= start_addr;
            fetch_left <= word_count;
            word_left  <= word_count;
            bitcnt     <= '0;
            shreg      <= '0;
            hold_vld   <= 1'b0;
        end else begin
            if (rd_launch) begin
                addr_q     <= addr_q + wbytes;
                fetch_left <= fetch_left - 1'b1;
            end
            if (done && !bus_we) begin
                hold     <= bus_rdata & rmask;
                hold_vld <= 1'b1;
            end
            if (shift_en) begin
                unique case (state)
                    ST_RD_STATUS: if (hold_vld) begin
                        shreg    <= SH_W'(hold);
                        hold_vld <= 1'b0;
                        bitcnt   <= '0;
                    end
                    ST_RD_DATA: begin
                        shreg  <= shreg >> 1;
                        bitcnt <= bitcnt + 1'b1;
                        if (last_bit) begin
                            bitcnt    <= '0;
                            word_left <= word_left - 1'b1;
                            if (last_word) shreg <= SH_W'(crc_nxt);
                        end
                    end
                    ST_RD_CRC: begin
                        shreg  <= shreg >> 1;
                        bitcnt <= bitcnt + 1'b1;
                    end
                    ST_WR_WAIT: if (tdi) begin
                        shreg  <= '0;
                        bitcnt <= '0;
                    end
                    ST_WR_DATA: begin
                        shreg  <= wword;
                        bitcnt <= bitcnt + 1'b1;
                        if (last_bit) begin
                            bitcnt <= '0;
                            wr_ok  <= !bus_req;
                            addr_q <= addr_q + wbytes;
                        end
                    end
                    ST_WR_STATUS: begin
                        shreg     <= '0;
                        bitcnt    <= '0;
                        word_left <= word_left - 1'b1;
                    end
                    ST_WR_CRC: begin
                        shreg  <= wword;
                        bitcnt <= bitcnt + 1'b1;
                        if (crc_last) match_q <= (wword[CRC_W-1:0] == crc_q);
                    end
                    default: ;
                endcase
            end
        end
    end

    burst_crc_serial #(.CRC_W(CRC_W), .POLY(CRC32_REFLECTED)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (start_ok),
        .step    (crc_step),
        .din     (crc_din),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    burst_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_we    (wr_launch),
        .launch_addr  (addr_q),
        .launch_wdata (DATA_W'(wword)),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_ack      (bus_ack),
        .bus_err      (bus_err),
        .done         (done),
        .err_flag     (err_flag),
        .err_addr     (err_addr)
    );
endmodule

// File: rtl/burst_xfer_engine_chk.sv
module burst_xfer_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  word_count,
    input logic              tdo,
    input logic              busy,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              err_flag,
    input logic [ADDR_W-1:0] err_addr
);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> (err_flag && $stable(err_addr)));

    p_err_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && bus_req && bus_ack && bus_err) |=> (err_flag && err_addr == $past(bus_addr)));

    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && word_count == '0) |=> !busy);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tdo);
endmodule

bind burst_xfer_engine burst_xfer_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_count (word_count),
    .tdo        (tdo),
    .busy       (busy),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .err_flag   (err_flag),
    .err_addr   (err_addr)
);

// File: tb/burst_xfer_engine_tb.sv
module burst_xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, start_write = 1'b0;
    logic [1:0]  start_size = '0;
    logic [31:0] start_addr = '0;
    logic [15:0] word_count = '0;
    logic        shift_en = 1'b0, tdi = 1'b0;
    logic        tdo, busy, bus_req, bus_we, err_flag;
    logic [31:0] bus_addr, bus_wdata, err_addr;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;

    int checks = 0, errors = 0;
    int lat = 0, lat_cnt = 0;
    bit inj = 1'b0;
    logic [31:0] bad_addr = '0;
    logic [31:0] log_a [0:63];
    logic [31:0] log_d [0:63];
    int log_n = 0;
    logic [31:0] wdat [0:15];

    always #4 clk = ~clk;

    burst_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
        .start_size(start_size), .start_addr(start_addr), .word_count(word_count),
        .shift_en(shift_en), .tdi(tdi), .tdo(tdo), .busy(busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .err_flag(err_flag), .err_addr(err_addr)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d, input int n);
        logic [31:0] r = c;
        for (int i = 0; i < n; i++) begin
            logic fb = d[i] ^ r[0];
            r = (r >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
        end
        return r;
    endfunction

    function automatic int nbits(input logic [1:0] s);
        return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus slave model
    initial forever begin
        @(negedge clk);
        if (bus_ack) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
        end else if (bus_req) begin
            if (lat_cnt >= lat) begin
                bus_ack   = 1'b1;
                bus_rdata = memf(bus_addr);
                bus_err   = inj && (bus_addr >= bad_addr);
                lat_cnt   = 0;
            end else lat_cnt++;
        end
    end

    // write monitor
    initial forever begin
        @(posedge clk);
        if (bus_req && bus_ack && bus_we && log_n < 64) begin
            log_a[log_n] = bus_addr;
            log_d[log_n] = bus_wdata;
            log_n++;
        end
    end

    task automatic sh(input logic b, output logic o);
        @(negedge clk);
        shift_en = 1'b1;
        tdi = b;
        #1 o = tdo;
    endtask

    task automatic idle_shift;
        @(negedge clk);
        shift_en = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic kick(input bit wr, input logic [1:0] sz, input logic [31:0] a, input int n);
        @(negedge clk);
        shift_en = 1'b0;
        start = 1'b1; start_write = wr; start_size = sz; start_addr = a; word_count = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_bus_idle;
        for (int k = 0; k < 100 && (bus_req || bus_ack); k++) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] sz, input logic [31:0] a0, input int n);
        int bits = nbits(sz);
        logic [31:0] crc = 32'hFFFFFFFF;
        logic [31:0] word, got_crc, mask;
        logic o;
        mask = (bits == 32) ? 32'hFFFFFFFF : ((32'd1 << bits) - 1);
        kick(1'b0, sz, a0, n);
        for (int w = 0; w < n; w++) begin
            int polls = 0;
            o = 1'b0;
            while (!o && polls < 64) begin sh(1'b0, o); polls++; end
            chk("R2 status bit", {31'd0, o}, 32'd1);
            word = '0;
            for (int b = 0; b < bits; b++) begin sh(1'b0, o); word[b] = o; end
            chk("R2/R7 read word", word, memf(a0 + 32'(w * (bits / 8))) & mask);
            crc = crc_upd(crc, memf(a0 + 32'(w * (bits / 8))) & mask, bits);
        end
        got_crc = '0;
        for (int b = 0; b < 32; b++) begin sh(1'b0, o); got_crc[b] = o; end
        chk("R1/R3 read crc", got_crc, crc);
        idle_shift();
        #1 chk("R3 idle after crc", {31'd0, busy}, 32'd0);
    endtask

    task automatic do_write(input logic [1:0] sz, input logic [31:0] a0, input int n,
                            input int lead, input logic [15:0] ok_mask,
                            input bit corrupt, input bit poke);
        int bits = nbits(sz);
        logic [31:0] crc = 32'hFFFFFFFF, hc, mask;
        logic o;
        int base;
        mask = (bits == 32) ? 32'hFFFFFFFF : ((32'd1 << bits) - 1);
        wait_bus_idle();
        base = log_n;
        kick(1'b1, sz, a0, n);
        if (poke) begin
            @(negedge clk);
            start = 1'b1; start_write = 1'b0; word_count = 16'd3;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < lead; k++) begin
            sh(1'b0, o);
            chk("R4 tdo low while waiting", {31'd0, o}, 32'd0);
        end
        sh(1'b1, o);
        for (int w = 0; w < n; w++) begin
            wdat[w] = $urandom() & mask;
            for (int b = 0; b < bits; b++) sh(wdat[w][b], o);
            crc = crc_upd(crc, wdat[w], bits);
            sh(1'b0, o);
            chk("R5 write status", {31'd0, o}, {31'd0, ok_mask[w]});
        end
        hc = corrupt ? (crc ^ 32'h00010000) : crc;
        for (int b = 0; b < 32; b++) sh(hc[b], o);
        sh(1'b0, o);
        chk("R6 match bit", {31'd0, o}, {31'd0, !corrupt});
        idle_shift();
        wait_bus_idle();
        for (int w = 0; w < n; w++) begin
            if (ok_mask[w]) begin
                chk("R4/R7 write addr", log_a[base], a0 + 32'(w * (bits / 8)));
                chk("R4 write data", log_d[base], wdat[w]);
                base++;
            end
        end
        chk("R5 write count", 32'(log_n), 32'(base));
    endtask

    initial begin
        logic [1:0] sz;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset tdo", {31'd0, tdo}, 32'd0);
        chk("R11 reset req", {31'd0, bus_req}, 32'd0);
        chk("R11 reset err", {31'd0, err_flag}, 32'd0);

        // R10 zero count ignored
        kick(1'b0, 2'd2, 32'h100, 0);
        #1 chk("R10 zero count ignored", {31'd0, busy}, 32'd0);

        // directed reads with slow and instant bus
        lat = 6; do_read(2'd2, 32'h0000_1000, 3);
        lat = 0; do_read(2'd0, 32'h0000_2003, 5);
        lat = 1; do_read(2'd1, 32'h0000_3002, 4);
        lat = 2; do_read(2'd3, 32'h0000_4000, 2);

        // directed writes: leading zeros, start while busy, corrupt crc
        lat = 0; do_write(2'd0, 32'h0000_5000, 3, 7, 16'hFFFF, 1'b0, 1'b0);
        lat = 1; do_write(2'd2, 32'h0000_6000, 2, 0, 16'hFFFF, 1'b1, 1'b1);
        lat = 2; do_write(2'd1, 32'h0000_7000, 4, 3, 16'hFFFF, 1'b0, 1'b0);
        // R5 slow bus drops the second word
        lat = 30; do_write(2'd0, 32'h0000_8000, 2, 1, 16'h0001, 1'b0, 1'b0);

        // constrained random mix
        for (int it = 0; it < 24; it++) begin
            lat = int'($urandom_range(0, 3));
            sz  = 2'($urandom_range(0, 3));
            n   = int'($urandom_range(1, 6));
            if ($urandom_range(0, 1) == 1)
                do_read(sz, {$urandom_range(0, 65535), 2'b00} , n);
            else
                do_write(sz, {$urandom_range(0, 65535), 2'b00}, n,
                         int'($urandom_range(0, 5)), 16'hFFFF, $urandom_range(0, 3) == 0, 1'b0);
        end

        // R9 bus errors: first failing address kept
        wait_bus_idle();
        chk("R9 no error before injection", {31'd0, err_flag}, 32'd0);
        inj = 1'b1; bad_addr = 32'h0000_9008; lat = 1;
        do_read(2'd2, 32'h0000_9000, 5);
        chk("R9 error flag", {31'd0, err_flag}, 32'd1);
        chk("R9 first error address", err_addr, 32'h0000_9008);
        inj = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule